// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a stack-machine arithmetic unit. The few most recent entries sit in a small register window. Older entries are moved to a backing memory through a synchronous single-port interface. Commands arrive on a valid/ready handshake. A command either pushes an operand, discards the top entry, or combines the two top entries with add, subtract, multiply or divide. The result replaces both operands.

Memory is used only when it is needed. A push into a full window writes the deepest window entry out to memory. An operation that leaves the window one entry short while memory still holds data reads the newest memory entry back in. This keeps both operands of the next operation in registers at all times. Free-running counters report how many memory writes (spills) and reads (fills) have occurred. Sticky flags report stack underflow, memory overflow and division by zero.

Top module: `eval_stack`

## Requirements
- R1: After reset, top_o and depth_o are 0, cmd_ready_o is 1, both reference counters are 0 and all three error flags are 0.
- R2: Command encoding on cmd_op_i is 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div. A push places cmd_data_i on top_o and raises depth_o by one. While depth_o is below the window depth, a push makes no memory access.
- R3: A push into a full window (with memory not full) writes the deepest window entry to memory address equal to the number of entries already in memory. The write happens in the cycle after acceptance, and spill_cnt_o increments by one.
- R4: When a pop or operation is accepted while memory holds entries, the block issues one read at address (memory entries − 1). The returned word becomes the deepest window entry, fill_cnt_o increments by one, and entries come back in last-in first-out order.
- R5: Operations use the second-from-top entry as left operand and the top entry as right operand on signed 16-bit words. Add, subtract and multiply wrap. Divide truncates toward zero. The result replaces both operands, so depth_o drops by one.
- R6: Division by a zero top entry yields 0xFFFF and sets the sticky div_zero_o flag.
- R7: A pop with depth 0, or an operation with depth below 2, sets sticky underflow_o and leaves top_o and depth_o unchanged.
- R8: A push when both the window and the memory area are full is dropped. It sets sticky overflow_o and leaves depth_o and top_o unchanged.
- R9: cmd_ready_o is low while a memory access is in progress. A spill holds it low for 1 cycle and a fill for 2 cycles (read, then capture). Otherwise it is low for no cycles.
- R10: With a 2-entry window, the sequence a b c * + a d c * + e - / yields (a+b*c)/(a+d*c−e) with exactly 4 spills and 4 fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | DATA_W | Operand for push |
| mem_we_o | output | 1 | Backing memory write strobe |
| mem_re_o | output | 1 | Backing memory read strobe |
| mem_addr_o | output | SP_W | Backing memory address |
| mem_wdata_o | output | DATA_W | Backing memory write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after mem_re_o |
| top_o | output | DATA_W | Top-of-stack value (0 when empty) |
| depth_o | output | DEP_W | Total entries in window plus memory |
| spill_cnt_o | output | CNT_W | Memory writes since reset |
| fill_cnt_o | output | CNT_W | Memory reads since reset |
| underflow_o | output | 1 | Sticky underflow flag |
| overflow_o | output | 1 | Sticky memory overflow flag |
| div_zero_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions check several rules on every cycle. The handshake is blocked during memory traffic. A push into a shallow stack stays in registers, while a push into a full window spills on the next cycle. Each spill and each fill advances its counter. An empty pop and an over-full push set their flags without moving the depth. The error flags stay set once raised. Only the bench scenarios can show the data-dependent behaviour: operand order, signed wrapping and truncation, and the divide-by-zero value. They also show that filled entries come back in last-in first-out order through the external memory, and that the reference expression costs exactly four spills and four fills.

// File: rtl/eval_stack_pkg.sv
package eval_stack_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FILL_RD,
    ST_FILL_WR
  } st_e;
endpackage

// File: rtl/eval_alu.sv
module eval_alu import eval_stack_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic [DATA_W-1:0] res_o,
  output logic              dz_o
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] a, b;
  assign a = lhs_i;
  assign b = rhs_i;

  always_comb begin
    dz_o  = 1'b0;
    res_o = rhs_i;
    unique case (op_i)
      OP_ADD: res_o = lhs_i + rhs_i;
      OP_SUB: res_o = lhs_i - rhs_i;
      OP_MUL: res_o = a * b;
      OP_DIV: begin
        if (rhs_i == '0) begin
          res_o = '1;
          dz_o  = 1'b1;
        end else if (lhs_i == MIN_V && rhs_i == '1) begin
          res_o = lhs_i;  // wraps
        end else begin
          res_o = a / b;
        end
      end
      default: res_o = rhs_i;
    endcase
  end
endmodule

// File: rtl/eval_window.sv
module eval_window #(
  parameter int DATA_W = 16,
  parameter int N      = 2,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              shrink_i,
  input  logic              bin_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DATA_W-1:0] second_o,
  output logic [DATA_W-1:0] bottom_o,
  output logic [CW-1:0]     cnt_o
);
  logic [DATA_W-1:0] ent_q [N];
  logic [CW-1:0]     cnt_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [DATA_W-1:0] up_v, dn_v;
    if (i == 0) begin : g_up_top
      assign up_v = push_data_i;
    end else begin : g_up_mid
      assign up_v = ent_q[i-1];
    end
    if (i == N - 1) begin : g_dn_last
      assign dn_v = '0;
    end else begin : g_dn_mid
      assign dn_v = ent_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q[i] <= '0;
      else if (push_i)                            ent_q[i] <= up_v;
      else if (shrink_i)                          ent_q[i] <= (i == 0 && bin_i) ? res_i : dn_v;
      else if (fill_i && cnt_q == CW'(i))         ent_q[i] <= fill_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (push_i && cnt_q != CW'(N))    cnt_q <= cnt_q + 1'b1;
    else if (shrink_i)                     cnt_q <= cnt_q - 1'b1;
    else if (fill_i)                       cnt_q <= cnt_q + 1'b1;
  end

  assign top_o    = ent_q[0];
  assign second_o = ent_q[1];
  assign bottom_o = ent_q[N-1];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/eval_stack.sv
module eval_stack import eval_stack_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int WIN_DEPTH = 2,
  parameter int MEM_DEPTH = 16,
  parameter int CNT_W     = 16,
  localparam int SP_W     = $clog2(MEM_DEPTH + 1),
  localparam int DEP_W    = $clog2(WIN_DEPTH + MEM_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DEP_W-1:0]  depth_o,
  output logic [CNT_W-1:0]  spill_cnt_o,
  output logic [CNT_W-1:0]  fill_cnt_o,
  output logic              underflow_o,
  output logic              overflow_o,
  output logic              div_zero_o
);
  localparam int CW = $clog2(WIN_DEPTH + 1);

  st_e               st_q;
  logic [SP_W-1:0]   sp_q;
  logic [DATA_W-1:0] spill_q;
  logic [CNT_W-1:0]  spill_cnt_q, fill_cnt_q;
  logic              unf_q, ovf_q, dz_q;

  logic [DATA_W-1:0] w_top, w_second, w_bottom, alu_res;
  logic [CW-1:0]     w_cnt;
  logic              alu_dz;

  op_e  op;
  logic accept, is_bin, win_full, mem_full, mem_empty;
  logic push_ok, shrink_ok, bin_ok;
  logic [DEP_W-1:0] depth;

  assign op        = op_e'(cmd_op_i);
  assign accept    = cmd_valid_i && (st_q == ST_IDLE);
  assign is_bin    = op inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV};
  assign win_full  = (w_cnt == CW'(WIN_DEPTH));
  assign mem_full  = (sp_q == SP_W'(MEM_DEPTH));
  assign mem_empty = (sp_q == '0);
  assign depth     = DEP_W'(w_cnt) + DEP_W'(sp_q);

  assign push_ok   = accept && op == OP_PUSH && !(win_full && mem_full);
  assign shrink_ok = accept && ((op == OP_POP && depth != '0) ||
                                (is_bin && depth >= DEP_W'(2)));
  assign bin_ok    = shrink_ok && is_bin;

  eval_window #(.DATA_W(DATA_W), .N(WIN_DEPTH)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_ok),
    .push_data_i (cmd_data_i),
    .shrink_i    (shrink_ok),
    .bin_i       (bin_ok),
    .res_i       (alu_res),
    .fill_i      (st_q == ST_FILL_WR),
    .fill_data_i (mem_rdata_i),
    .top_o       (w_top),
    .second_o    (w_second),
    .bottom_o    (w_bottom),
    .cnt_o       (w_cnt)
  );

  eval_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op),
    .lhs_i (w_second),
    .rhs_i (w_top),
    .res_o (alu_res),
    .dz_o  (alu_dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sp_q        <= '0;
      spill_q     <= '0;
      spill_cnt_q <= '0;
      fill_cnt_q  <= '0;
      unf_q       <= 1'b0;
      ovf_q       <= 1'b0;
      dz_q        <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (push_ok && win_full) begin
            spill_q <= w_bottom;  // deepest entry leaves the window
            st_q    <= ST_SPILL;
          end
          if (shrink_ok && !mem_empty) st_q <= ST_FILL_RD;
          if (accept && op == OP_PUSH && win_full && mem_full) ovf_q <= 1'b1;
          if (accept && (op == OP_POP || is_bin) && !shrink_ok) unf_q <= 1'b1;
          if (bin_ok && alu_dz) dz_q <= 1'b1;
        end
        ST_SPILL: begin
          sp_q        <= sp_q + 1'b1;
          spill_cnt_q <= spill_cnt_q + 1'b1;
          st_q        <= ST_IDLE;
        end
        ST_FILL_RD: st_q <= ST_FILL_WR;
        ST_FILL_WR: begin
          sp_q       <= sp_q - 1'b1;
          fill_cnt_q <= fill_cnt_q + 1'b1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign mem_we_o    = (st_q == ST_SPILL);
  assign mem_re_o    = (st_q == ST_FILL_RD);
  assign mem_addr_o  = (st_q == ST_FILL_RD) ? sp_q - 1'b1 : sp_q;
  assign mem_wdata_o = spill_q;
  assign top_o       = w_top;
  assign depth_o     = depth;
  assign spill_cnt_o = spill_cnt_q;
  assign fill_cnt_o  = fill_cnt_q;
  assign underflow_o = unf_q;
  assign overflow_o  = ovf_q;
  assign div_zero_o  = dz_q;
endmodule

// File: rtl/eval_stack_chk.sv
module eval_stack_chk #(
  parameter int DATA_W    = 16,
  parameter int WIN_DEPTH = 2,
  parameter int MEM_DEPTH = 16,
  parameter int CNT_W     = 16,
  localparam int DEP_W    = $clog2(WIN_DEPTH + MEM_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [2:0]        cmd_op_i,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [DATA_W-1:0] top_o,
  input logic [DEP_W-1:0]  depth_o,
  input logic [CNT_W-1:0]  spill_cnt_o,
  input logic [CNT_W-1:0]  fill_cnt_o,
  input logic              underflow_o,
  input logic              overflow_o,
  input logic              div_zero_o
);
  localparam logic [DEP_W-1:0] WIN_D = DEP_W'(WIN_DEPTH);
  localparam logic [DEP_W-1:0] TOT_D = DEP_W'(WIN_DEPTH + MEM_DEPTH);

  logic acc_push, acc_pop;
  assign acc_push = cmd_valid_i && cmd_ready_o && cmd_op_i == 3'd0;
  assign acc_pop  = cmd_valid_i && cmd_ready_o && cmd_op_i == 3'd1;

  a_r9_busy_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> !cmd_ready_o);

  a_r2_shallow_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_push && depth_o < WIN_D) |=> (!mem_we_o && depth_o == $past(depth_o) + 1'b1));

  a_r3_spill_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_push && depth_o >= WIN_D && depth_o < TOT_D) |=> (mem_we_o && !cmd_ready_o));

  a_r3_spill_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> spill_cnt_o == $past(spill_cnt_o) + 1'b1);

  a_r4_fill_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (!mem_re_o && !cmd_ready_o));

  a_r4_fill_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_re_o, 2) |-> fill_cnt_o == $past(fill_cnt_o) + 1'b1);

  a_r7_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_pop && depth_o == '0) |=> (underflow_o && depth_o == '0));

  a_r7_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  a_r8_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_push && depth_o == TOT_D) |=> (overflow_o && $stable(depth_o) && $stable(top_o) && !mem_we_o));

  a_r8_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r6_div_zero_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |=> div_zero_o);
endmodule

bind eval_stack eval_stack_chk #(
  .DATA_W(DATA_W), .WIN_DEPTH(WIN_DEPTH), .MEM_DEPTH(MEM_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .top_o       (top_o),
  .depth_o     (depth_o),
  .spill_cnt_o (spill_cnt_o),
  .fill_cnt_o  (fill_cnt_o),
  .underflow_o (underflow_o),
  .overflow_o  (overflow_o),
  .div_zero_o  (div_zero_o)
);

// File: tb/tb_eval_stack.sv
module tb_eval_stack;
  localparam int W    = 16;
  localparam int N    = 2;
  localparam int M    = 16;
  localparam int CW   = 16;
  localparam int SPW  = $clog2(M + 1);
  localparam int DW   = $clog2(N + M + 1);
  localparam int TOT  = N + M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_ready, mem_we, mem_re, unf, ovf, dz;
  logic [SPW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata, top;
  logic [DW-1:0] depth;
  logic [CW-1:0] spill_cnt, fill_cnt;

  always #2.5 clk = ~clk;

  eval_stack #(.DATA_W(W), .WIN_DEPTH(N), .MEM_DEPTH(M), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .top_o(top), .depth_o(depth), .spill_cnt_o(spill_cnt), .fill_cnt_o(fill_cnt),
    .underflow_o(unf), .overflow_o(ovf), .div_zero_o(dz)
  );

  // backing memory model, synchronous read
  logic [W-1:0] mem [M];
  int we_seen = 0, re_seen = 0;
  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr] <= mem_wdata; we_seen <= we_seen + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_addr]; re_seen <= re_seen + 1; end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic [W-1:0] top;
    int           depth;
    int           busy;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] model[$];

  function automatic logic [W-1:0] calc(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W-1:0] sa, sb;
    sa = a; sb = b;
    case (op)
      3'd2: return a + b;
      3'd3: return a - b;
      3'd4: return sa * sb;
      default: return (b == '0) ? '1 : W'(sa / sb);
    endcase
  endfunction

  // monitor: compares completed command against the scoreboard head
  task automatic monitor(input int busy);
    exp_t e;
    e = sb_q.pop_front();
    chk({e.tag, " top"},   int'(top),   int'(e.top));
    chk({e.tag, " depth"}, int'(depth), e.depth);
    chk("R9 busy cycles",  busy,        e.busy);
  endtask

  // driver: predicts, queues, drives, waits for completion
  task automatic send(input logic [2:0] op, input logic [W-1:0] d, input string tag);
    exp_t e;
    int sz, busy;
    logic [W-1:0] a, b;
    sz = model.size();
    e.busy = 0;
    if (op == 3'd0) begin
      if (sz < TOT) begin
        if (sz >= N) e.busy = 1;
        model.push_back(d);
      end
    end else if (op == 3'd1) begin
      if (sz >= 1) begin
        if (sz > N) e.busy = 2;
        void'(model.pop_back());
      end
    end else if (sz >= 2) begin
      b = model.pop_back();
      a = model.pop_back();
      model.push_back(calc(op, a, b));
      if (sz > N) e.busy = 2;
    end
    e.top   = (model.size() != 0) ? model[$] : '0;
    e.depth = model.size();
    e.tag   = tag;
    sb_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0;
    while (!cmd_ready) begin busy++; @(negedge clk); end
    monitor(busy);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    model.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int we0, re0;
    do_reset();
    // R1 reset state
    chk("R1 top", int'(top), 0);
    chk("R1 depth", int'(depth), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 spill", int'(spill_cnt), 0);
    chk("R1 fill", int'(fill_cnt), 0);
    chk("R1 flags", int'({unf, ovf, dz}), 0);

    // R10 reference expression, a=10 b=5 c=2 d=1 e=3 -> 20/9 = 2
    we0 = we_seen; re0 = re_seen;
    send(3'd0, 16'd10, "R10"); send(3'd0, 16'd5, "R10"); send(3'd0, 16'd2, "R10");
    send(3'd4, '0, "R10"); send(3'd2, '0, "R10");
    send(3'd0, 16'd10, "R10"); send(3'd0, 16'd1, "R10"); send(3'd0, 16'd2, "R10");
    send(3'd4, '0, "R10"); send(3'd2, '0, "R10");
    send(3'd0, 16'd3, "R10"); send(3'd3, '0, "R10"); send(3'd5, '0, "R10");
    chk("R10 result", int'(top), 2);
    chk("R10 spills", int'(spill_cnt), 4);
    chk("R10 fills", int'(fill_cnt), 4);
    chk("R3 port writes", we_seen - we0, 4);
    chk("R4 port reads", re_seen - re0, 4);

    // R2 / R5 arithmetic ordering and wrapping
    do_reset();
    send(3'd0, 16'd9, "R2 push"); send(3'd0, 16'd4, "R2 push");
    chk("R2 no spill when shallow", int'(spill_cnt), 0);
    send(3'd3, '0, "R5 sub");
    chk("R5 sub 9-4", int'(top), 5);
    send(3'd0, 16'hFFF9, "R2 push"); send(3'd0, 16'd2, "R2 push");
    send(3'd5, '0, "R5 div");
    chk("R5 div -7/2", int'(top), int'(16'hFFFD));
    send(3'd0, 16'd300, "R2 push"); send(3'd0, 16'd300, "R2 push");
    send(3'd4, '0, "R5 mul");
    chk("R5 mul wrap", int'(top), 24464);
    chk("R6 no flag yet", int'(dz), 0);
    send(3'd0, 16'd5, "R2 push"); send(3'd0, 16'd0, "R2 push");
    send(3'd5, '0, "R6 div0");
    chk("R6 div0 value", int'(top), int'(16'hFFFF));
    chk("R6 flag", int'(dz), 1);
    send(3'd2, '0, "R5 add");
    chk("R6 sticky", int'(dz), 1);

    // R7 underflow
    do_reset();
    send(3'd1, '0, "R7 empty pop");
    chk("R7 flag empty pop", int'(unf), 1);
    do_reset();
    send(3'd0, 16'd5, "R2 push");
    send(3'd2, '0, "R7 short add");
    chk("R7 flag short add", int'(unf), 1);
    chk("R7 top kept", int'(top), 5);

    // R3 / R8 / R4 fill to the limit, overflow, then drain LIFO
    do_reset();
    for (int i = 1; i <= TOT; i++) send(3'd0, W'(i), "R3 deep push");
    chk("R3 spill count", int'(spill_cnt), M);
    chk("R8 no flag at limit", int'(ovf), 0);
    send(3'd0, 16'd99, "R8 overflow push");
    chk("R8 flag", int'(ovf), 1);
    chk("R8 spill unchanged", int'(spill_cnt), M);
    for (int i = 0; i < TOT; i++) send(3'd1, '0, "R4 drain pop");
    chk("R4 fill count", int'(fill_cnt), M);
    chk("R4 empty after drain", int'(depth), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule